// File: doc/BRIEF.md
# Timer-Compare PWM Edge Scheduler

This block makes a PWM waveform by scheduling edges against a free-running 16-bit timer. It does not use a counter that restarts every period. Each compare register holds the timer value at which its next event fires. When the timer reaches that value, the block reloads the register in the same clock cycle by adding an interval to it. All additions wrap modulo 2^W, so the waveform runs on unchanged through timer overflow.

The block has two scheduling schemes.

- **Alternating-step scheme** (`mode` = 0): one compare channel flips the output at every event. It then adds either the high time or the low time to its compare value. An internal phase bit, which flips at each event, picks which of the two is added.
- **Dual-channel scheme** (`mode` = 1): channel 0 drives the output high and channel 1 drives it low. Each channel adds the full period at every one of its own events. The two channels stay a fixed high time apart.

While `en` is low, the output rests at `init_level`. The compare registers are loaded at the moment the block is enabled. The period, the high time and the mode are expected to stay stable while `en` is high.

Top module: `pwm_edge_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pwm_out` is 0 and both strobes `match0` and `match1` are 0.
- R2: While `en` is low, no strobe fires, and `pwm_out` equals the value `init_level` had at the previous clock edge.
- R3: The first clock edge that samples `en` high arms the block. `match0` is high during the very next cycle. Call that cycle index 0.
- R4: With `mode` = 0 and 0 < `on_time` < `period`:
  - `match0` fires at cycle indices i where i mod `period` is 0 or equals `on_time`.
  - Each event inverts `pwm_out` from the following cycle on.
  - With `init_level` = 0, `pwm_out` is therefore 1 in cycle i ≥ 1 exactly when (i−1) mod `period` < `on_time`.
  - With `init_level` = 1, the waveform is the inverse.
- R5: With `mode` = 0, `match1` never fires.
- R6: With `mode` = 1, `match0` fires at i mod `period` = 0, and `pwm_out` is 1 in the following cycle.
- R7: With `mode` = 1, `match1` fires at cycles i ≥ `on_time` where (i − `on_time`) mod `period` = 0. Unless `match0` fires in the same cycle, `pwm_out` is 0 in the following cycle.
- R8: If `on_time` = 0, `pwm_out` is held at 0. If `on_time` ≥ `period`, `pwm_out` is held at 1. In both cases channel 0 still fires every `period` cycles in either mode.
- R9: The event spacing stays exact across timer wrap-around. A schedule that runs for more than 2^16 cycles keeps the same pattern.
- R10: Edges one cycle apart are never missed. With `on_time` = 1, each period has a high phase of exactly one cycle, in both modes.
- R11: After `en` returns low, from the next cycle on `pwm_out` equals `init_level` and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the scheduler; a rising level arms the compares |
| mode | input | 1 | 0 = alternating-step single channel, 1 = dual-channel set/clear |
| init_level | input | 1 | Output level while idle and at arming |
| period | input | W | Full period in timer ticks |
| on_time | input | W | High time in timer ticks |
| pwm_out | output | 1 | PWM waveform (registered) |
| match0 | output | 1 | Channel 0 compare event, one cycle per event |
| match1 | output | 1 | Channel 1 compare event (dual-channel scheme only) |

## Verification
The bench goes after three failure classes.

- **Adjacent edges:** a one-tick high time. A design that reloaded late, or that compared with an inequality, would skip an edge there. The output would then stay high for a whole period, or the strobes would double up.
- **Timer wrap:** a run past the 16-bit wrap. A compare sum that saturated, or was truncated wrongly, would shift or lose the event that follows the overflow.
- **Degenerate high times and phase handling:** zero and full high times, and both idle levels. A design that still stepped the compare by the zero high time would stall channel 0 for a whole timer revolution. A design that tied the output to the phase bit would produce an inverted waveform when the idle level is 1.

// File: rtl/pwm_edge_sched.sv
module pwm_edge_sched #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mode,
  input  logic         init_level,
  input  logic [W-1:0] period,
  input  logic [W-1:0] on_time,
  output logic         pwm_out,
  output logic         match0,
  output logic         match1
);

  logic [W-1:0] timer, cmp0, cmp1;
  logic         armed, phase, out_q;

  wire hold_lo = (on_time == '0);
  wire hold_hi = !hold_lo && (on_time >= period);
  wire hold    = hold_lo || hold_hi;

  wire [W-1:0] off_time = period - on_time;
  wire [W-1:0] step0    = (mode || hold) ? period : (phase ? off_time : on_time);

  assign match0  = armed && (timer == cmp0);
  assign match1  = armed && mode && (timer == cmp1);
  assign pwm_out = out_q;

  logic out_nxt;
  always_comb begin
    out_nxt = out_q;
    if (hold_lo)      out_nxt = 1'b0;
    else if (hold_hi) out_nxt = 1'b1;
    else if (mode) begin
      if (match1)      out_nxt = 1'b0;
      else if (match0) out_nxt = 1'b1;
    end else if (match0) begin
      out_nxt = ~out_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
      cmp0  <= '0;
      cmp1  <= '0;
      armed <= 1'b0;
      phase <= 1'b0;
      out_q <= 1'b0;
    end else begin
      timer <= timer + W'(1);
      if (!en) begin
        armed <= 1'b0;
        phase <= 1'b0;
        out_q <= init_level;
      end else if (!armed) begin
        armed <= 1'b1;
        phase <= 1'b0;
        cmp0  <= timer + W'(1);
        cmp1  <= timer + W'(1) + on_time;
        out_q <= hold_lo ? 1'b0 : (hold_hi ? 1'b1 : init_level);
      end else begin
        if (match0) cmp0 <= cmp0 + step0;
        if (match1) cmp1 <= cmp1 + period;
        if ((!mode && match0) || (mode && match1)) phase <= ~phase;
        out_q <= out_nxt;
      end
    end
  end

endmodule

// File: rtl/pwm_edge_sched_chk.sv
module pwm_edge_sched_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         mode,
  input logic         init_level,
  input logic [W-1:0] period,
  input logic [W-1:0] on_time,
  input logic         pwm_out,
  input logic         match0,
  input logic         match1
);

  wire normal = (on_time != '0) && (on_time < period);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_out == $past(init_level)) && !match0 && !match1); // R2

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && match0 && normal) |=> (pwm_out != $past(pwm_out))); // R4

  AST_TOGGLE_NO_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode) |-> !match1); // R5

  AST_REMAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && match0 && !match1 && normal) |=> pwm_out); // R6

  AST_REMAP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && match1 && normal) |=> !pwm_out); // R7

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && on_time == '0) |=> !pwm_out); // R8

  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && on_time != '0 && on_time >= period) |=> pwm_out); // R8

endmodule

bind pwm_edge_sched pwm_edge_sched_chk #(.W(W)) i_chk (.*);

// File: tb/test_pwm_edge_sched.sv
module test_pwm_edge_sched;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, mode = 1'b0, init_level = 1'b0;
  logic [W-1:0] period = '0, on_time = '0;
  logic pwm_out, match0, match1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_edge_sched #(.W(W)) i_pwm_edge_sched (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .init_level(init_level),
    .period(period), .on_time(on_time),
    .pwm_out(pwm_out), .match0(match0), .match1(match1)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "pwm_out in reset", int'(pwm_out), 0);
    check("R1", "match0 in reset", int'(match0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "strobes after reset", int'(match0 | match1 | pwm_out), 0);
  endtask

  task automatic t_idle();
    int bad = 0;
    init_level = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (pwm_out != 1'b1 || match0 || match1) bad++;
      @(negedge clk);
    end
    check("R2", "idle with level 1 mismatches", bad, 0);
    init_level = 1'b0;
    @(negedge clk);
    check("R2", "idle follows level 0", int'(pwm_out | match0 | match1), 0);
  endtask

  task automatic run_case(input string req, input bit m, input int t1, input int t2,
                          input bit lvl, input int n);
    int bad_m0 = 0, bad_m1 = 0, bad_out = 0;
    int first_m0 = -1, first_m1 = -1, first_out = -1;
    bit lo, hi, nrm, e0, e1, eo;
    lo = (t1 == 0);
    hi = !lo && (t1 >= t2);
    nrm = !lo && !hi;
    mode = m; on_time = W'(t1); period = W'(t2); init_level = lvl;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R3", "match0 in first armed cycle", int'(match0), 1);
    for (int i = 0; i < n; i++) begin
      if (m || !nrm) e0 = (i % t2 == 0);
      else           e0 = (i % t2 == 0) || (i % t2 == t1);
      e1 = m && (i >= t1) && ((i - t1) % t2 == 0);
      if (lo)          eo = 1'b0;
      else if (hi)     eo = 1'b1;
      else if (i == 0) eo = lvl;
      else begin
        eo = ((i - 1) % t2) < t1;
        if (!m && lvl) eo = !eo;
      end
      if (match0 != e0)  begin bad_m0++;  if (first_m0 < 0)  first_m0 = i;  end
      if (match1 != e1)  begin bad_m1++;  if (first_m1 < 0)  first_m1 = i;  end
      if (pwm_out != eo) begin bad_out++; if (first_out < 0) first_out = i; end
      @(negedge clk);
    end
    check(req, $sformatf("match0 mismatches (first at %0d)", first_m0), bad_m0, 0);
    check(m ? req : "R5", $sformatf("match1 mismatches (first at %0d)", first_m1), bad_m1, 0);
    check(req, $sformatf("pwm_out mismatches (first at %0d)", first_out), bad_out, 0);
    en = 1'b0;
    @(negedge clk);
    check("R11", "pwm_out back to idle level", int'(pwm_out), int'(lvl));
    check("R11", "strobes silent after disable", int'(match0 | match1), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    run_case("R4", 1'b0, 3, 10, 1'b0, 45);
    run_case("R4", 1'b0, 4, 9, 1'b1, 40);
    run_case("R6 R7", 1'b1, 3, 10, 1'b0, 45);
    run_case("R6 R7", 1'b1, 6, 8, 1'b1, 40);
    run_case("R10", 1'b1, 1, 5, 1'b0, 30);
    run_case("R10", 1'b0, 1, 5, 1'b0, 30);
    run_case("R8", 1'b0, 0, 7, 1'b1, 30);
    run_case("R8", 1'b1, 9, 7, 1'b0, 30);
    run_case("R8", 1'b0, 7, 7, 1'b0, 30);
    run_case("R9", 1'b0, 7000, 20000, 1'b0, 70000);
    run_case("R9", 1'b1, 12000, 30000, 1'b0, 70000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule